// File: doc/BRIEF.md
# Floor Call Latch and Position Classifier

This block remembers which floors of an eight-stop lift shaft have an outstanding request. Each floor has a momentary, already-synchronized switch input; a press away from the car's current floor latches a pending bit for that floor. The bit stays set after the switch is released. It is flushed only once the car has arrived at that floor and stayed there for a programmable serving time.

Alongside the latches, the block compares the current floor index with every floor number. It then reports whether any pending request lies above the car, below it, or at the floor it occupies. A floor sequencer uses these three flags and the raw pending mask to choose the direction of travel and to decide when to stop.

The serving time is a cycle count. It starts when the car reaches a floor and is dropped if the car moves away before it expires. A later return to that floor starts the full count again.

Top module: `floor_call_tracker`

## Requirements
- R1: While `rst_n` is low, every pending bit and all three position flags are 0.
- R2: If switch bit i is 1 at a rising edge while `cur_floor` is not i, then `pending[i]` is 1 after that edge.
- R3: A set pending bit stays 1 after its switch returns to 0, for as long as the car is not at that floor.
- R4: A switch press for the floor the car currently occupies never sets that floor's bit. A switch held at the car's floor does not stop the flush once the serving time has elapsed.
- R5: Suppose `cur_floor` takes value F after one rising edge and then stays at F. `pending[F]` keeps its value through the next SERVE_CYCLES+1 rising edges and is 0 after edge SERVE_CYCLES+2.
- R6: `call_above` is 1 exactly when some pending bit has an index greater than `cur_floor`.
- R7: `call_below` is 1 exactly when some pending bit has an index less than `cur_floor`.
- R8: `call_here` equals `pending[cur_floor]`.
- R9: If the car leaves floor F before the serving time expires, `pending[F]` stays set. A return to F restarts the full count of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released in step with `clk` |
| call_btn | input | NUM_FLOORS | Synchronized call switches, bit i for floor i |
| cur_floor | input | FLOOR_W | Binary index of the floor the car is at |
| pending | output | NUM_FLOORS | Latched outstanding request, bit i for floor i |
| call_above | output | 1 | A pending request exists above the car |
| call_below | output | 1 | A pending request exists below the car |
| call_here | output | 1 | A pending request exists at the car's floor |

## Verification
The assertions rely on two things about the inputs: `cur_floor` always holds a valid floor index, and `call_btn` is already synchronous to `clk`. With the default eight floors and a three-bit index, every code is valid. The stimulus changes `call_btn` and `cur_floor` only just after a rising edge and holds them across the next edge. It never presents a floor outside the shaft, so each set, hold and flush decision is taken on settled inputs.

// File: rtl/elev_call_pkg.sv
package elev_call_pkg;

  // Relation of one floor index to the car's present floor.
  typedef enum logic [1:0] {
    REL_NONE  = 2'b00,
    REL_ABOVE = 2'b01,
    REL_BELOW = 2'b10,
    REL_HERE  = 2'b11
  } floor_rel_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/call_serve_timer.sv
module call_serve_timer #(
  parameter int unsigned FLOOR_W      = 3,
  parameter int unsigned SERVE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLOOR_W-1:0] cur_floor,
  output logic               serve_ok
);

  localparam int unsigned CNT_W = $clog2(SERVE_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(SERVE_CYCLES);

  logic [FLOOR_W-1:0] last_q, last_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               moved;
  logic               cnt_en;

  always_comb begin
    moved  = (cur_floor != last_q);
    last_d = cur_floor;
    cnt_en = moved || (cnt_q < CNT_LIM);
    cnt_d  = cnt_q;
    if (moved) begin
      cnt_d = '0;
    end else if (cnt_q < CNT_LIM) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    serve_ok = !moved && (cnt_q == CNT_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else begin
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LIM); // R5

  AST_MOVE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_floor != last_q) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/call_latch_bank.sv
module call_latch_bank #(
  parameter int unsigned NUM_FLOORS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FLOORS-1:0] call_btn,
  input  logic [NUM_FLOORS-1:0] at_floor,
  input  logic                  serve_ok,
  output logic [NUM_FLOORS-1:0] pend_q
);

  logic [NUM_FLOORS-1:0] pend_d;
  logic [NUM_FLOORS-1:0] pend_en;

  for (genvar i = 0; i < NUM_FLOORS; i++) begin : g_floor
    logic do_set;
    logic do_flush;

    always_comb begin
      do_set     = call_btn[i] && !at_floor[i];
      do_flush   = at_floor[i] && serve_ok;
      pend_en[i] = do_set || do_flush;
      pend_d[i]  = do_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
      end else if (pend_en[i]) begin
        pend_q[i] <= pend_d[i];
      end
    end

    AST_SET_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
      (call_btn[i] && !at_floor[i]) |=> pend_q[i]); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!call_btn[i] && !at_floor[i]) |=> $stable(pend_q[i])); // R3

    AST_NO_SET_HERE: assert property (@(posedge clk) disable iff (!rst_n)
      (at_floor[i] && !pend_q[i]) |=> !pend_q[i]); // R4

    AST_FLUSH_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[i]) |-> $past(at_floor[i] && serve_ok)); // R5
  end

endmodule

// File: rtl/call_locator.sv
module call_locator
  import elev_call_pkg::*;
#(
  parameter int unsigned NUM_FLOORS = 8,
  parameter int unsigned FLOOR_W    = 3
) (
  input  logic [NUM_FLOORS-1:0] pend,
  input  logic [FLOOR_W-1:0]    cur_floor,
  output logic [NUM_FLOORS-1:0] at_floor,
  output logic                  any_above,
  output logic                  any_below,
  output logic                  any_here
);

  floor_rel_e            rel [NUM_FLOORS];
  logic [NUM_FLOORS-1:0] hit_above;
  logic [NUM_FLOORS-1:0] hit_below;
  logic [NUM_FLOORS-1:0] hit_here;

  for (genvar i = 0; i < NUM_FLOORS; i++) begin : g_cmp
    localparam logic [FLOOR_W-1:0] MY_IDX = FLOOR_W'(i);

    always_comb begin
      if (MY_IDX > cur_floor) begin
        rel[i] = REL_ABOVE;
      end else if (MY_IDX < cur_floor) begin
        rel[i] = REL_BELOW;
      end else begin
        rel[i] = REL_HERE;
      end
      at_floor[i]  = (rel[i] == REL_HERE);
      hit_above[i] = pend[i] && (rel[i] == REL_ABOVE);
      hit_below[i] = pend[i] && (rel[i] == REL_BELOW);
      hit_here[i]  = pend[i] && (rel[i] == REL_HERE);
    end
  end

  always_comb begin
    any_above = |hit_above;
    any_below = |hit_below;
    any_here  = |hit_here;
  end

  always_comb begin
    if (int'(cur_floor) < NUM_FLOORS) begin
      AST_ONE_MATCH: assert ($onehot(at_floor)); // R8
    end
  end

endmodule

// File: rtl/floor_call_tracker.sv
module floor_call_tracker
  import elev_call_pkg::*;
#(
  parameter int unsigned NUM_FLOORS   = 8,
  parameter int unsigned SERVE_CYCLES = 4,
  localparam int unsigned FLOOR_W     = idx_width(NUM_FLOORS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FLOORS-1:0] call_btn,
  input  logic [FLOOR_W-1:0]    cur_floor,
  output logic [NUM_FLOORS-1:0] pending,
  output logic                  call_above,
  output logic                  call_below,
  output logic                  call_here
);

  logic [NUM_FLOORS-1:0] at_floor;
  logic                  serve_ok;

  call_serve_timer #(
    .FLOOR_W      (FLOOR_W),
    .SERVE_CYCLES (SERVE_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_floor (cur_floor),
    .serve_ok  (serve_ok)
  );

  call_latch_bank #(
    .NUM_FLOORS (NUM_FLOORS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_btn (call_btn),
    .at_floor (at_floor),
    .serve_ok (serve_ok),
    .pend_q   (pending)
  );

  call_locator #(
    .NUM_FLOORS (NUM_FLOORS),
    .FLOOR_W    (FLOOR_W)
  ) u_loc (
    .pend      (pending),
    .cur_floor (cur_floor),
    .at_floor  (at_floor),
    .any_above (call_above),
    .any_below (call_below),
    .any_here  (call_here)
  );

  AST_FLAGS_NEED_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !(call_above || call_below || call_here)); // R6

  AST_NO_SERVE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_floor) |-> !serve_ok); // R9

  AST_HERE_MEANS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    call_here |-> (pending != '0)); // R8

endmodule

// File: tb/floor_call_tracker_test.sv
module floor_call_tracker_test;

  localparam int unsigned NF    = 8;
  localparam int unsigned SERVE = 4;
  localparam int unsigned FW    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] call_btn;
  logic [FW-1:0] cur_floor;
  logic [NF-1:0] pending;
  logic          call_above, call_below, call_here;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  floor_call_tracker #(.NUM_FLOORS(NF), .SERVE_CYCLES(SERVE)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_btn   (call_btn),
    .cur_floor  (cur_floor),
    .pending    (pending),
    .call_above (call_above),
    .call_below (call_below),
    .call_here  (call_here)
  );

  always #2 clk = ~clk;

  // Advance n rising edges, then settle 1 ns past the last one.
  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Model of the three flags from the requirement text.
  task automatic chk_flags(input string req);
    logic ea, eb, eh;
    ea = 1'b0; eb = 1'b0; eh = 1'b0;
    for (int f = 0; f < NF; f++) begin
      if (pending[f] && f > int'(cur_floor)) ea = 1'b1;
      if (pending[f] && f < int'(cur_floor)) eb = 1'b1;
      if (pending[f] && f == int'(cur_floor)) eh = 1'b1;
    end
    chk(call_above == ea, {req, " R6 above"}, call_above, ea);
    chk(call_below == eb, {req, " R7 below"}, call_below, eb);
    chk(call_here  == eh, {req, " R8 here"},  call_here,  eh);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; call_btn = '0; cur_floor = '0;
    tick(3);
    chk(pending == '0, "R1 pending in reset", pending, 0);
    chk(!(call_above || call_below || call_here), "R1 flags in reset",
        {call_above, call_below, call_here}, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(2);
    chk(pending == '0, "R1 pending after release", pending, 0);
  endtask

  task automatic t_latch;
    call_btn = 8'h20;
    tick(1);
    chk(pending == 8'h20, "R2 set floor 5", pending, 8'h20);
    call_btn = '0;
    tick(4);
    chk(pending == 8'h20, "R3 held after release", pending, 8'h20);
    chk_flags("latch");
    chk(call_above == 1'b1, "R6 call above floor 0", call_above, 1);
  endtask

  task automatic t_press_here;
    call_btn = 8'h01;
    tick(3);
    chk(pending[0] == 1'b0, "R4 press at own floor", pending[0], 0);
    call_btn = '0;
    tick(1);
    chk(pending == 8'h20, "R4 others untouched", pending, 8'h20);
  endtask

  task automatic t_serve;
    cur_floor = 3'd5;
    tick(SERVE + 1);
    chk(pending[5] == 1'b1, "R5 kept during serving", pending[5], 1);
    chk_flags("serving");
    chk(call_here == 1'b1, "R8 here while serving", call_here, 1);
    tick(1);
    chk(pending[5] == 1'b0, "R5 flushed on time", pending[5], 0);
    chk_flags("served");
  endtask

  task automatic t_abandon;
    call_btn = 8'h04;
    tick(1);
    call_btn = '0;
    chk(pending == 8'h04, "R2 set floor 2", pending, 8'h04);
    chk(call_below == 1'b1, "R7 call below floor 5", call_below, 1);
    cur_floor = 3'd2;
    tick(3);
    cur_floor = 3'd3;
    tick(10);
    chk(pending[2] == 1'b1, "R9 call kept after leaving", pending[2], 1);
    chk_flags("left");
    cur_floor = 3'd2;
    tick(SERVE + 1);
    chk(pending[2] == 1'b1, "R9 full count restarted", pending[2], 1);
    tick(1);
    chk(pending[2] == 1'b0, "R9 flushed after restart", pending[2], 0);
  endtask

  task automatic t_both_ways;
    cur_floor = 3'd3;
    tick(1);
    call_btn = 8'h82;
    tick(1);
    call_btn = '0;
    chk(pending == 8'h82, "R2 two calls", pending, 8'h82);
    chk(call_above && call_below && !call_here, "R6 R7 both sides",
        {call_above, call_below, call_here}, 3'b110);
    chk_flags("both");
    cur_floor = 3'd7;
    call_btn  = 8'h80;
    tick(SERVE + 2);
    chk(pending[7] == 1'b0, "R4 held switch still flushed", pending[7], 0);
    tick(2);
    chk(pending[7] == 1'b0, "R4 held switch no reset", pending[7], 0);
    call_btn = '0;
    chk_flags("top floor");
    chk(call_below == 1'b1, "R7 floor 1 below 7", call_below, 1);
  endtask

  initial begin
    t_reset();
    t_latch();
    t_press_here();
    t_serve();
    t_abandon();
    t_both_ways();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule